// File: doc/BRIEF.md
# Double-Buffered Endpoint Bank Controller

This block steers the two descriptor slots of one device endpoint address. In normal operation slot 0 carries OUT traffic and slot 1 carries IN traffic, each on its own. When ping-pong operation is switched on, both slots carry data in one configured direction and act as a pair of banks. The serial engine then works on one bank while the processor or a DMA channel drains or fills the other, and the roles swap after every successful transaction.

The engine raises a request strobe with the token direction. One cycle later the controller answers with either a grant, naming the bank and its buffer base address, or a NAK. It answers with a NAK when the chosen bank is still held by software or the direction does not match the configured one. On a completion strobe the controller hands the bank to software by setting its busy flag and latching the byte count. Software hands the bank back with a per-bank release pulse.

Top module: `ppbuf_ctrl`

## Requirements
- R1: After a synchronous reset, the toggle, both busy flags, both byte counts, grant, NAK and the active flag are all 0.
- R2: With ping-pong off, an OUT request (dir 0) uses bank 0 and an IN request (dir 1) uses bank 1, and the granted base address is the configured base of that bank.
- R3: With ping-pong on, a request in the configured direction uses the bank named by the toggle, and a request in the other direction is answered with a NAK.
- R4: The toggle flips on each successful completion while ping-pong is on; an abort leaves it unchanged.
- R5: A completion sets the busy flag of the active bank and stores the byte count, up to 1023 in a 10-bit field, for that bank.
- R6: A request whose selected bank is busy gets a NAK and no grant.
- R7: A release pulse clears that bank's busy flag; releasing a bank that is not busy changes nothing.
- R8: Turning ping-pong off clears the toggle on the next clock edge, even mid-operation.
- R9: While a transaction is active, further requests produce neither grant nor NAK.
- R10: Grant and NAK are one-cycle pulses, due one cycle after the request, never both high. Grant bank holds the bank of the last answered request.
- R11: A completion and a release of the same bank in the same cycle leave that bank busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pp_en | input | 1 | Ping-pong enable |
| cfg_pp_dir | input | 1 | Direction served in ping-pong mode (1 = IN) |
| cfg_base0 | input | ADDR_W | Buffer base of bank 0 |
| cfg_base1 | input | ADDR_W | Buffer base of bank 1 |
| xfer_req | input | 1 | Engine asks to start a transaction |
| xfer_dir | input | 1 | Token direction (1 = IN, 0 = OUT) |
| xfer_done | input | 1 | Active transaction completed successfully |
| xfer_abort | input | 1 | Active transaction ended without success |
| xfer_cnt | input | CNT_W | Byte count of the completed transaction |
| cpu_release | input | 2 | Per-bank hand-back from software |
| grant_o | output | 1 | Transaction may start |
| nak_o | output | 1 | Request refused |
| grant_bank_o | output | 1 | Bank of the last answered request |
| grant_base_o | output | ADDR_W | Base address of the granted bank |
| toggle_o | output | 1 | Bank selected for the next ping-pong transaction |
| busy_o | output | 2 | Per-bank software ownership |
| active_o | output | 1 | A transaction is in progress |
| cnt0_o | output | CNT_W | Byte count stored for bank 0 |
| cnt1_o | output | CNT_W | Byte count stored for bank 1 |

## Verification
Every output is a register, so each result is due exactly one edge after the cycle whose inputs cause it. Grant or NAK follows a request by one cycle. Busy, byte count and toggle follow a completion or release by one cycle, and the toggle clears one cycle after ping-pong is turned off. The bench drives inputs on the falling edge, waits for the next rising edge and samples 1 ns later, so each check reads the state produced by exactly one stimulus cycle before the next stimulus lands.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  localparam int NBANK = 2;

  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } dir_e;

  typedef logic [$clog2(NBANK)-1:0] bank_t;
endpackage

// File: rtl/ppbuf_sel.sv
module ppbuf_sel
  import ppbuf_pkg::*;
(
  input  logic             pp_en,
  input  logic             pp_dir,
  input  logic             req,
  input  logic             req_dir,
  input  logic             toggle,
  input  logic             active,
  input  logic [NBANK-1:0] busy,
  output bank_t            sel_bank,
  output logic             go,
  output logic             refuse
);
  logic dir_ok;
  logic ask;

  always_comb begin
    sel_bank = pp_en ? bank_t'(toggle) : bank_t'(req_dir);
    dir_ok   = !pp_en || (req_dir == pp_dir);
    ask      = req && !active;
    go       = ask && dir_ok && !busy[sel_bank];
    refuse   = ask && !go;
  end
endmodule

// File: rtl/ppbuf_bank.sv
module ppbuf_bank #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      if (set_i) begin
        busy_o <= 1'b1;
        cnt_o  <= cnt_i;
      end else if (clr_i) begin
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ppbuf_ctrl.sv
module ppbuf_ctrl
  import ppbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_pp_en,
  input  logic              cfg_pp_dir,
  input  logic [ADDR_W-1:0] cfg_base0,
  input  logic [ADDR_W-1:0] cfg_base1,
  input  logic              xfer_req,
  input  logic              xfer_dir,
  input  logic              xfer_done,
  input  logic              xfer_abort,
  input  logic [CNT_W-1:0]  xfer_cnt,
  input  logic [1:0]        cpu_release,
  output logic              grant_o,
  output logic              nak_o,
  output logic              grant_bank_o,
  output logic [ADDR_W-1:0] grant_base_o,
  output logic              toggle_o,
  output logic [1:0]        busy_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt0_o,
  output logic [CNT_W-1:0]  cnt1_o
);
  bank_t             sel_bank;
  bank_t             act_bank;
  logic              go;
  logic              refuse;
  logic              done_ok;
  logic [NBANK-1:0]  busy_q;
  logic [CNT_W-1:0]  cnt_q [NBANK];
  logic [ADDR_W-1:0] base_arr [NBANK];

  assign base_arr[0] = cfg_base0;
  assign base_arr[1] = cfg_base1;
  assign done_ok     = xfer_done && active_o;

  ppbuf_sel u_sel (
    .pp_en    (cfg_pp_en),
    .pp_dir   (cfg_pp_dir),
    .req      (xfer_req),
    .req_dir  (xfer_dir),
    .toggle   (toggle_o),
    .active   (active_o),
    .busy     (busy_q),
    .sel_bank (sel_bank),
    .go       (go),
    .refuse   (refuse)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ppbuf_bank #(.CNT_W(CNT_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_i  (done_ok && (act_bank == bank_t'(b))),
      .clr_i  (cpu_release[b]),
      .cnt_i  (xfer_cnt),
      .busy_o (busy_q[b]),
      .cnt_o  (cnt_q[b])
    );
  end

  assign busy_o = busy_q;
  assign cnt0_o = cnt_q[0];
  assign cnt1_o = cnt_q[1];

  // Transaction tracking and answer registers
  always_ff @(posedge clk) begin
    if (rst) begin
      active_o     <= 1'b0;
      act_bank     <= '0;
      grant_o      <= 1'b0;
      nak_o        <= 1'b0;
      grant_bank_o <= 1'b0;
      grant_base_o <= '0;
    end else begin
      grant_o <= go;
      nak_o   <= refuse;
      if (go) begin
        active_o     <= 1'b1;
        act_bank     <= sel_bank;
        grant_base_o <= base_arr[sel_bank];
      end else if (active_o && (xfer_done || xfer_abort)) begin
        active_o <= 1'b0;
      end
      if (go || refuse) grant_bank_o <= sel_bank;
    end
  end

  // Bank toggle: flips on success in ping-pong mode, cleared otherwise
  always_ff @(posedge clk) begin
    if (rst || !cfg_pp_en) toggle_o <= 1'b0;
    else if (done_ok)      toggle_o <= ~toggle_o;
  end
endmodule

// File: rtl/ppbuf_chk.sv
module ppbuf_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_pp_en,
  input logic             xfer_req,
  input logic             xfer_dir,
  input logic             xfer_done,
  input logic [1:0]       cpu_release,
  input logic             grant_o,
  input logic             nak_o,
  input logic             toggle_o,
  input logic [1:0]       busy_o,
  input logic             active_o,
  input logic [CNT_W-1:0] cnt0_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!toggle_o && busy_o == 2'b00 && !grant_o && !nak_o && !active_o));

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_pp_en && xfer_done && active_o) |=> (toggle_o != $past(toggle_o)));

  assert_done_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && active_o) |=> (busy_o != 2'b00));

  assert_busy_nak_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !active_o && !cfg_pp_en && busy_o[xfer_dir]) |=> (nak_o && !grant_o));

  assert_release_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_release[0] && !xfer_done) |=> !busy_o[0]);

  assert_pp_off_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_pp_en |=> !toggle_o);

  assert_ignore_active_R9: assert property (@(posedge clk) disable iff (rst)
    active_o |=> (!grant_o && !nak_o));

  assert_no_both_R10: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && nak_o));

  assert_grant_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> !grant_o);

  assert_done_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && active_o && cpu_release == 2'b11) |=> (busy_o != 2'b00));
endmodule

bind ppbuf_ctrl ppbuf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_pp_en   (cfg_pp_en),
  .xfer_req    (xfer_req),
  .xfer_dir    (xfer_dir),
  .xfer_done   (xfer_done),
  .cpu_release (cpu_release),
  .grant_o     (grant_o),
  .nak_o       (nak_o),
  .toggle_o    (toggle_o),
  .busy_o      (busy_o),
  .active_o    (active_o),
  .cnt0_o      (cnt0_o)
);

// File: tb/tb_ppbuf_ctrl.sv
`timescale 1ns/1ps
module tb_ppbuf_ctrl;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 10;
  localparam int NVEC   = 18;

  // {pp_en,pp_dir,req,dir,done,abort,rel[1:0],e_grant,e_nak,e_bank,e_tog,e_busy[1:0],e_act,0}
  localparam logic [15:0] VEC [NVEC] = '{
    16'b00_1000_00_1000_00_10,  // R2 OUT -> bank0
    16'b00_0010_00_0000_01_00,  // R5 done
    16'b00_1000_00_0100_01_00,  // R6 bank0 busy
    16'b00_1100_00_1010_01_10,  // R2 IN -> bank1
    16'b00_0001_00_0010_01_00,  // abort
    16'b00_0000_01_0010_00_00,  // R7 release 0
    16'b11_1100_00_1000_00_10,  // R3 pp bank0
    16'b11_0010_00_0001_01_00,  // R4 flip
    16'b11_1100_00_1011_01_10,  // R3 pp bank1
    16'b11_0010_00_0010_11_00,  // R4 flip back
    16'b11_1100_00_0100_11_00,  // R6 pp busy
    16'b11_1000_00_0100_11_00,  // R3 wrong dir
    16'b11_0000_01_0000_10_00,  // R7
    16'b11_1100_00_1000_10_10,  // R3
    16'b11_1100_00_0000_10_10,  // R9 ignored
    16'b11_0010_10_0001_01_00,  // R5 done + release other
    16'b11_0000_11_0001_00_00,  // R7 release non-busy no effect
    16'b00_0000_00_0000_00_00   // R8 pp off clears toggle
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_pp_en = 1'b0, cfg_pp_dir = 1'b0;
  logic [ADDR_W-1:0] cfg_base0 = 16'h0100, cfg_base1 = 16'h0200;
  logic              xfer_req = 1'b0, xfer_dir = 1'b0, xfer_done = 1'b0, xfer_abort = 1'b0;
  logic [CNT_W-1:0]  xfer_cnt = '0;
  logic [1:0]        cpu_release = 2'b00;
  logic              grant_o, nak_o, grant_bank_o, toggle_o, active_o;
  logic [ADDR_W-1:0] grant_base_o;
  logic [1:0]        busy_o;
  logic [CNT_W-1:0]  cnt0_o, cnt1_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ppbuf_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic pe, input logic pd, input logic rq, input logic dr,
                       input logic dn, input logic ab, input logic [1:0] rl,
                       input logic [CNT_W-1:0] ct);
    @(negedge clk);
    cfg_pp_en = pe; cfg_pp_dir = pd; xfer_req = rq; xfer_dir = dr;
    xfer_done = dn; xfer_abort = ab; cpu_release = rl; xfer_cnt = ct;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; xfer_req = 0; xfer_done = 0; xfer_abort = 0; cpu_release = 0; cfg_pp_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #40000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1 toggle", toggle_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 grant/nak", {grant_o, nak_o}, 0);
    check("R1 active", active_o, 0);
    check("R1 counts", {cnt0_o, cnt1_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      drive(v[15], v[14], v[13], v[12], v[11], v[10], v[9:8], CNT_W'(i));
      check($sformatf("R10 vec%0d grant", i), grant_o, v[7]);
      check($sformatf("R6 vec%0d nak", i), nak_o, v[6]);
      check($sformatf("R3 vec%0d bank", i), grant_bank_o, v[5]);
      check($sformatf("R4 vec%0d toggle", i), toggle_o, v[4]);
      check($sformatf("R5 vec%0d busy", i), busy_o, v[3:2]);
      check($sformatf("R9 vec%0d active", i), active_o, v[1]);
    end

    // R1 again after a mid-run reset
    do_reset();
    #1;
    check("R1 busy after rerun", busy_o, 0);

    // R2 base address and R5 full byte count
    drive(0, 0, 1, 1, 0, 0, 2'b00, 0);
    check("R2 grant IN", grant_o, 1);
    check("R2 base1", grant_base_o, 16'h0200);
    drive(0, 0, 0, 0, 1, 0, 2'b00, 10'd1023);
    check("R5 cnt1 max", cnt1_o, 1023);
    check("R5 busy bank1", busy_o, 2'b10);

    // R7 releasing a non-busy bank has no effect
    drive(0, 0, 0, 0, 0, 0, 2'b01, 0);
    check("R7 no effect", busy_o, 2'b10);
    drive(0, 0, 0, 0, 0, 0, 2'b10, 0);
    check("R7 cleared", busy_o, 2'b00);

    // R11 completion and release of the same bank together
    drive(0, 0, 1, 0, 0, 0, 2'b00, 0);
    check("R2 base0", grant_base_o, 16'h0100);
    drive(0, 0, 0, 0, 1, 0, 2'b01, 10'd5);
    check("R11 busy kept", busy_o, 2'b01);
    check("R5 cnt0", cnt0_o, 5);

    // R4 abort leaves toggle alone
    drive(1, 0, 0, 0, 0, 0, 2'b01, 0);
    drive(1, 0, 1, 0, 0, 0, 2'b00, 0);
    check("R3 pp OUT grant", {grant_o, grant_bank_o}, 2'b10);
    drive(1, 0, 0, 0, 0, 1, 2'b00, 0);
    check("R4 abort toggle", toggle_o, 0);
    check("R4 abort busy", busy_o, 2'b00);

    // R8 disable mid-operation
    drive(1, 0, 1, 0, 0, 0, 2'b00, 0);
    drive(1, 0, 0, 0, 1, 0, 2'b00, 10'd7);
    check("R4 toggled", toggle_o, 1);
    drive(0, 0, 0, 0, 0, 0, 2'b00, 0);
    check("R8 toggle cleared", toggle_o, 0);
    drive(0, 0, 1, 0, 0, 0, 2'b00, 0);
    check("R6 nak separate mode", {grant_o, nak_o}, 2'b01);
    drive(0, 0, 0, 0, 0, 0, 2'b00, 0);
    check("R10 nak pulse", nak_o, 0);

    finished = 1'b1;
    report();
  end
endmodule